// File: doc/BRIEF.md
# DMA Descriptor Submission Register File

This block is the software-facing front end of one uni-directional DMA channel. Software fills a set of staging registers over a simple 32-bit register port: source and destination addresses, row length, row count, strides and flags. It then commits them by writing the start register. On a commit the block copies the staged values into a single submission slot and stamps them with a hardware-allocated 5-bit transfer ID. It offers the slot to the transfer engine over a valid/ready descriptor port.

The engine reports each finished transfer by its ID on a completion input. The block collects finished IDs in a bitmap that clears when read, so each finish is reported once. It raises two interrupt causes through a write-one-to-clear pending register and a blocking mask: the slot became free, and a transfer finished. Feature discovery works by write-probing. Fields of features that are not built read back reduced or as zero, so software can tell which options the instance carries.

A read returns data on `reg_rdata` in the cycle after `reg_rd` is sampled. A write takes effect at the clock edge on which `reg_wr` is sampled.

Top module: `dma_submit_regs`

## Requirements
- R1: After reset the following reads hold: control 0x400 reads 0, IRQ mask 0x80 reads 0x3, IRQ pending 0x84 reads 0, transfer ID 0x404 reads 0, start 0x408 reads 0 and done 0x428 reads 0. `irq` and `desc_valid` are low.
- R2: Register 0x404 reads the ID that the next accepted commit will carry. Each accepted commit advances the ID by one, modulo 32, so 31 is followed by 0. `desc_id` carries the ID stamped at commit. Register 0x42C reads the ID of the descriptor that the engine took most recently.
- R3: A write of 1 in bit 0 to 0x408 is accepted only while control bit 0 (run) is 1 and the slot is empty. From acceptance until the engine takes the descriptor or the channel is aborted, 0x408 bit 0 reads 1. A rejected write changes neither the next ID nor the offered descriptor.
- R4: The following staging registers are copied into the slot at commit and appear on the `desc_*` outputs: destination address 0x410, source address 0x414, X length 0x418, Y length 0x41C, destination stride 0x420, source stride 0x424, and flags 0x40C (bit 0 cyclic, bit 1 last, bit 2 partial report). Staging writes made after the commit do not alter the offered descriptor.
- R5: While control bit 1 (pause) is 1, `desc_valid` stays low even with the slot full. Clearing the bit offers the slot again.
- R6: A control write with bit 0 = 0 aborts the channel and empties the slot. After the abort, `desc_valid` is low and 0x408 reads 0. The slot stays empty after the channel is enabled again.
- R7: A completion with `cpl_id` = k, where k < 31, sets bit k of 0x428. A read of 0x428 returns the bitmap and clears it. A completion that arrives in the same cycle as the read is missing from that read and shows in the next one. A completion with ID 31 sets no bit, and bit 31 always reads 0.
- R8: Pending 0x84 bit 0 is set when the engine takes a descriptor. Bit 1 is set on each completion. Writing 1 to a pending bit clears it, and a set in the same cycle wins over the clear. Register 0x88 reads pending AND NOT mask.
- R9: `irq` is high exactly while some pending bit has its mask bit in 0x80 at 0; a mask bit of 1 blocks that cause.
- R10: With the default parameters, the write probes give these read-backs: flags bit 0 reads 0, because cyclic is not built. X length reads 0x0000FFFF after an all-ones write. Y length reads 1 after a write of 1, because 2D is built. Destination address reads 0, because that side is not memory-mapped. Source address reads back the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| eng_enable | output | 1 | Channel run bit to the engine |
| eng_pause | output | 1 | Channel pause bit to the engine |
| desc_valid | output | 1 | Slot offered to the engine |
| desc_ready | input | 1 | Engine takes the offered descriptor |
| desc_id | output | 5 | Transfer ID of the offered descriptor |
| desc_flags | output | 3 | Flags of the offered descriptor |
| desc_dst_addr | output | 32 | Destination address |
| desc_src_addr | output | 32 | Source address |
| desc_x_len | output | 32 | Row length minus one |
| desc_y_len | output | 32 | Row count minus one |
| desc_dst_stride | output | 32 | Destination stride |
| desc_src_stride | output | 32 | Source stride |
| cpl_valid | input | 1 | Engine reports a finished transfer |
| cpl_id | input | 5 | ID of the finished transfer |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can collide in one clock. In the first, a read of the done register, which clears it, meets a completion that sets a bit in it. The bench issues both in the same cycle. It expects the read to return the bitmap from before the completion, and the following read to show the new bit. In the second, a write-one-to-clear of the finished-interrupt bit meets a completion. The bench expects the pending bit to survive. The bench also places a rejected commit, one made while the slot is full, ahead of the engine's take. A scoreboard then checks that the descriptor the engine receives is still the one from the first commit.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 12;
    localparam int ID_W    = 5;
    localparam int NUM_IDS = 1 << ID_W;
    localparam int FLG_W   = 3;
    localparam int IRQ_W   = 2;

    localparam int CTL_RUN       = 0;
    localparam int CTL_HOLD      = 1;
    localparam int IRQ_SLOT_FREE = 0;
    localparam int IRQ_FINISHED  = 1;
    localparam int FLG_CYCLIC    = 0;

    // ID NUM_IDS-1 has no done bit; the top bit is reserved.
    localparam logic [REG_W-1:0] DONE_LIVE = {1'b0, {(REG_W-1){1'b1}}};

    typedef enum logic [4:0] {
        R_NONE, R_IRQ_MASK, R_IRQ_PEND, R_IRQ_SRC, R_CTL, R_NEXT_ID,
        R_START, R_FLAGS, R_DADDR, R_SADDR, R_XLEN, R_YLEN,
        R_DSTRIDE, R_SSTRIDE, R_DONE, R_ACT_ID, R_STAT
    } reg_e;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [FLG_W-1:0] flags;
        logic [REG_W-1:0] dst_addr;
        logic [REG_W-1:0] src_addr;
        logic [REG_W-1:0] x_len;
        logic [REG_W-1:0] y_len;
        logic [REG_W-1:0] dst_stride;
        logic [REG_W-1:0] src_stride;
    } desc_t;

    function automatic reg_e reg_decode(input logic [ADDR_W-1:0] a);
        case (a)
            12'h080: return R_IRQ_MASK;
            12'h084: return R_IRQ_PEND;
            12'h088: return R_IRQ_SRC;
            12'h400: return R_CTL;
            12'h404: return R_NEXT_ID;
            12'h408: return R_START;
            12'h40C: return R_FLAGS;
            12'h410: return R_DADDR;
            12'h414: return R_SADDR;
            12'h418: return R_XLEN;
            12'h41C: return R_YLEN;
            12'h420: return R_DSTRIDE;
            12'h424: return R_SSTRIDE;
            12'h428: return R_DONE;
            12'h42C: return R_ACT_ID;
            12'h430: return R_STAT;
            default: return R_NONE;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] set_over_clear(
        input logic [REG_W-1:0] cur,
        input logic [REG_W-1:0] clr,
        input logic [REG_W-1:0] set);
        return (cur & ~clr) | set;
    endfunction
endpackage

// File: rtl/dsr_cfg_regs.sv
module dsr_cfg_regs
    import dsr_pkg::*;
#(
    parameter int XLEN_W     = 16,
    parameter int YLEN_W     = 16,
    parameter bit HAS_CYCLIC = 1'b0,
    parameter bit HAS_2D     = 1'b1,
    parameter bit SRC_IS_MEM = 1'b1,
    parameter bit DST_IS_MEM = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_e             wr_reg,
    input  logic [REG_W-1:0] wdata,
    output desc_t            staged
);
    logic [REG_W-1:0] src_q, dst_q, xlen_q, ylen_q, sstr_q, dstr_q;
    logic [FLG_W-1:1] flg_hi_q;
    logic             cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xlen_q   <= '0;
            sstr_q   <= '0;
            dstr_q   <= '0;
            flg_hi_q <= '0;
        end else if (wr_en) begin
            case (wr_reg)
                R_XLEN:    xlen_q   <= REG_W'(wdata[XLEN_W-1:0]);
                R_SSTRIDE: sstr_q   <= wdata;
                R_DSTRIDE: dstr_q   <= wdata;
                R_FLAGS:   flg_hi_q <= wdata[FLG_W-1:1];
                default: ;
            endcase
        end
    end

    generate
        if (SRC_IS_MEM) begin : g_src_mem
            always_ff @(posedge clk) begin
                if (rst) src_q <= '0;
                else if (wr_en && wr_reg == R_SADDR) src_q <= wdata;
            end
        end else begin : g_src_stream
            assign src_q = '0;
        end

        if (DST_IS_MEM) begin : g_dst_mem
            always_ff @(posedge clk) begin
                if (rst) dst_q <= '0;
                else if (wr_en && wr_reg == R_DADDR) dst_q <= wdata;
            end
        end else begin : g_dst_stream
            assign dst_q = '0;
        end

        if (HAS_2D) begin : g_rows
            always_ff @(posedge clk) begin
                if (rst) ylen_q <= '0;
                else if (wr_en && wr_reg == R_YLEN) ylen_q <= REG_W'(wdata[YLEN_W-1:0]);
            end
        end else begin : g_no_rows
            assign ylen_q = '0;
        end

        if (HAS_CYCLIC) begin : g_cyc
            always_ff @(posedge clk) begin
                if (rst) cyc_q <= 1'b0;
                else if (wr_en && wr_reg == R_FLAGS) cyc_q <= wdata[FLG_CYCLIC];
            end
        end else begin : g_no_cyc
            assign cyc_q = 1'b0;
        end
    endgenerate

    always_comb begin
        staged            = '0;
        staged.flags      = {flg_hi_q, cyc_q};
        staged.dst_addr   = dst_q;
        staged.src_addr   = src_q;
        staged.x_len      = xlen_q;
        staged.y_len      = ylen_q;
        staged.dst_stride = dstr_q;
        staged.src_stride = sstr_q;
    end
endmodule

// File: rtl/dsr_submit.sv
module dsr_submit
    import dsr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  reg_e            wr_reg,
    input  logic [1:0]      wbits,
    input  desc_t           staged,
    input  logic            desc_ready,
    output desc_t           slot,
    output logic            desc_valid,
    output logic            slot_busy,
    output logic [ID_W-1:0] next_id,
    output logic [ID_W-1:0] active_id,
    output logic            run,
    output logic            hold,
    output logic            slot_freed,
    output logic            abort_evt
);
    logic ctl_wr, start_ok;

    assign ctl_wr     = wr_en && (wr_reg == R_CTL);
    assign abort_evt  = ctl_wr && !wbits[CTL_RUN];
    assign start_ok   = wr_en && (wr_reg == R_START) && wbits[0] && run && !slot_busy;
    assign desc_valid = slot_busy && run && !hold;
    assign slot_freed = desc_valid && desc_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            hold      <= 1'b0;
            slot_busy <= 1'b0;
            slot      <= '0;
            next_id   <= '0;
            active_id <= '0;
        end else begin
            if (ctl_wr) begin
                run  <= wbits[CTL_RUN];
                hold <= wbits[CTL_HOLD];
            end
            if (slot_freed) active_id <= slot.id;
            if (start_ok) begin
                slot      <= staged;
                slot.id   <= next_id;
                next_id   <= next_id + 1'b1;
                slot_busy <= 1'b1;
            end else if (abort_evt || slot_freed) begin
                slot_busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dsr_events.sv
module dsr_events
    import dsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_e             wr_reg,
    input  logic [1:0]       wbits,
    input  logic             rd_en,
    input  reg_e             rd_reg,
    input  logic             slot_freed,
    input  logic             cpl_valid,
    input  logic [ID_W-1:0]  cpl_id,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] pend,
    output logic [REG_W-1:0] done_bits,
    output logic             irq
);
    logic [IRQ_W-1:0] pend_set, pend_clr;
    logic [REG_W-1:0] done_set, done_clr, pend_next;

    always_comb begin
        pend_set                = '0;
        pend_set[IRQ_SLOT_FREE] = slot_freed;
        pend_set[IRQ_FINISHED]  = cpl_valid;
        pend_clr = (wr_en && wr_reg == R_IRQ_PEND) ? wbits : '0;
        pend_next = set_over_clear(REG_W'(pend), REG_W'(pend_clr), REG_W'(pend_set));

        done_set = '0;
        if (cpl_valid) done_set[cpl_id] = 1'b1;
        done_set = done_set & DONE_LIVE;
        done_clr = (rd_en && rd_reg == R_DONE) ? '1 : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask      <= '1;
            pend      <= '0;
            done_bits <= '0;
        end else begin
            if (wr_en && wr_reg == R_IRQ_MASK) mask <= wbits;
            pend      <= pend_next[IRQ_W-1:0];
            done_bits <= set_over_clear(done_bits, done_clr, done_set);
        end
    end

    assign irq = |(pend & ~mask);
endmodule

// File: rtl/dma_submit_regs.sv
module dma_submit_regs
    import dsr_pkg::*;
#(
    parameter int XLEN_W     = 16,
    parameter int YLEN_W     = 16,
    parameter bit HAS_CYCLIC = 1'b0,
    parameter bit HAS_2D     = 1'b1,
    parameter bit SRC_IS_MEM = 1'b1,
    parameter bit DST_IS_MEM = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              eng_enable,
    output logic              eng_pause,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [ID_W-1:0]   desc_id,
    output logic [FLG_W-1:0]  desc_flags,
    output logic [REG_W-1:0]  desc_dst_addr,
    output logic [REG_W-1:0]  desc_src_addr,
    output logic [REG_W-1:0]  desc_x_len,
    output logic [REG_W-1:0]  desc_y_len,
    output logic [REG_W-1:0]  desc_dst_stride,
    output logic [REG_W-1:0]  desc_src_stride,
    input  logic              cpl_valid,
    input  logic [ID_W-1:0]   cpl_id,
    output logic              irq
);
    reg_e             acc_reg;
    desc_t            staged, slot;
    logic             slot_busy, run, hold, slot_freed, abort_evt;
    logic [ID_W-1:0]  next_id, active_id;
    logic [IRQ_W-1:0] mask, pend;
    logic [REG_W-1:0] done_bits, rd_value;

    assign acc_reg = reg_decode(reg_addr);

    dsr_cfg_regs #(
        .XLEN_W(XLEN_W), .YLEN_W(YLEN_W), .HAS_CYCLIC(HAS_CYCLIC),
        .HAS_2D(HAS_2D), .SRC_IS_MEM(SRC_IS_MEM), .DST_IS_MEM(DST_IS_MEM)
    ) i_cfg (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_reg(acc_reg),
        .wdata(reg_wdata), .staged(staged)
    );

    dsr_submit i_submit (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_reg(acc_reg),
        .wbits(reg_wdata[1:0]), .staged(staged), .desc_ready(desc_ready),
        .slot(slot), .desc_valid(desc_valid), .slot_busy(slot_busy),
        .next_id(next_id), .active_id(active_id), .run(run), .hold(hold),
        .slot_freed(slot_freed), .abort_evt(abort_evt)
    );

    dsr_events i_events (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_reg(acc_reg),
        .wbits(reg_wdata[1:0]), .rd_en(reg_rd), .rd_reg(acc_reg),
        .slot_freed(slot_freed), .cpl_valid(cpl_valid), .cpl_id(cpl_id),
        .mask(mask), .pend(pend), .done_bits(done_bits), .irq(irq)
    );

    always_comb begin
        case (acc_reg)
            R_IRQ_MASK: rd_value = REG_W'(mask);
            R_IRQ_PEND: rd_value = REG_W'(pend);
            R_IRQ_SRC:  rd_value = REG_W'(pend & ~mask);
            R_CTL:      rd_value = REG_W'({hold, run});
            R_NEXT_ID:  rd_value = REG_W'(next_id);
            R_START:    rd_value = REG_W'(slot_busy);
            R_FLAGS:    rd_value = REG_W'(staged.flags);
            R_DADDR:    rd_value = staged.dst_addr;
            R_SADDR:    rd_value = staged.src_addr;
            R_XLEN:     rd_value = staged.x_len;
            R_YLEN:     rd_value = staged.y_len;
            R_DSTRIDE:  rd_value = staged.dst_stride;
            R_SSTRIDE:  rd_value = staged.src_stride;
            R_DONE:     rd_value = done_bits;
            R_ACT_ID:   rd_value = REG_W'(active_id);
            R_STAT:     rd_value = REG_W'({hold, run, slot_busy});
            default:    rd_value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_value;
    end

    assign eng_enable      = run;
    assign eng_pause       = hold;
    assign desc_id         = slot.id;
    assign desc_flags      = slot.flags;
    assign desc_dst_addr   = slot.dst_addr;
    assign desc_src_addr   = slot.src_addr;
    assign desc_x_len      = slot.x_len;
    assign desc_y_len      = slot.y_len;
    assign desc_dst_stride = slot.dst_stride;
    assign desc_src_stride = slot.src_stride;
endmodule

// File: rtl/dsr_checker.sv
module dsr_checker
    import dsr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [ID_W-1:0]  desc_id,
    input logic [REG_W-1:0] desc_x_len,
    input logic             eng_pause,
    input logic             cpl_valid,
    input logic [ID_W-1:0]  cpl_id,
    input logic             slot_busy,
    input logic             abort_evt,
    input logic [ID_W-1:0]  next_id,
    input logic [IRQ_W-1:0] pend,
    input logic [REG_W-1:0] done_bits
);
    AST_ID_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_busy) |-> (next_id == $past(next_id) + 1'b1) && (desc_id == $past(next_id))); // R2

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        slot_busy && !(desc_valid && desc_ready) && !abort_evt |=> slot_busy); // R3

    AST_DESC_STABLE: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=> $stable(desc_id) && $stable(desc_x_len)); // R4

    AST_PAUSE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        eng_pause |-> !desc_valid); // R5

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && (cpl_id != ID_W'(NUM_IDS - 1)) |=> done_bits[$past(cpl_id)]); // R7

    AST_SLOT_FREE_PEND: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_ready |=> pend[IRQ_SLOT_FREE]); // R8

    AST_FINISH_PEND: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |=> pend[IRQ_FINISHED]); // R8
endmodule

bind dma_submit_regs dsr_checker i_dsr_checker (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_id(desc_id), .desc_x_len(desc_x_len), .eng_pause(eng_pause),
    .cpl_valid(cpl_valid), .cpl_id(cpl_id), .slot_busy(slot_busy),
    .abort_evt(abort_evt), .next_id(next_id), .pend(pend), .done_bits(done_bits)
);

// File: tb/test_dma_submit_regs.sv
`timescale 1ns/1ps
module test_dma_submit_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_enable, eng_pause, desc_valid;
    logic        desc_ready = 1'b0;
    logic [4:0]  desc_id;
    logic [2:0]  desc_flags;
    logic [31:0] desc_dst_addr, desc_src_addr, desc_x_len, desc_y_len;
    logic [31:0] desc_dst_stride, desc_src_stride;
    logic        cpl_valid = 1'b0;
    logic [4:0]  cpl_id = '0;
    logic        irq;

    int n_checks = 0;
    int n_err    = 0;

    typedef struct {
        logic [4:0]  id;
        logic [2:0]  fl;
        logic [31:0] da, sa, xl, yl, ds, ss;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;
    logic [4:0]  model_id = '0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    dma_submit_regs i_dma_submit_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_enable(eng_enable), .eng_pause(eng_pause),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_id(desc_id),
        .desc_flags(desc_flags), .desc_dst_addr(desc_dst_addr),
        .desc_src_addr(desc_src_addr), .desc_x_len(desc_x_len),
        .desc_y_len(desc_y_len), .desc_dst_stride(desc_dst_stride),
        .desc_src_stride(desc_src_stride), .cpl_valid(cpl_valid),
        .cpl_id(cpl_id), .irq(irq)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // Driver: stage, commit, and push the expected descriptor
    task automatic commit(input logic [31:0] sa, input logic [31:0] da,
                          input logic [31:0] xl, input logic [31:0] yl,
                          input logic [31:0] ss, input logic [31:0] ds,
                          input logic [2:0] fl);
        exp_t e;
        wr(12'h414, sa); wr(12'h410, da); wr(12'h418, xl); wr(12'h41C, yl);
        wr(12'h424, ss); wr(12'h420, ds); wr(12'h40C, {29'b0, fl});
        wr(12'h408, 32'h1);
        e.id = model_id; e.sa = sa; e.da = 32'h0;
        e.xl = xl & 32'h0000_FFFF; e.yl = yl & 32'h0000_FFFF;
        e.ss = ss; e.ds = ds; e.fl = fl & 3'b110;
        exp_q.push_back(e);
        model_id = model_id + 5'd1;
    endtask

    task automatic take();
        @(negedge clk); desc_ready = 1'b1;
        @(negedge clk); desc_ready = 1'b0;
    endtask

    task automatic finish_id(input logic [4:0] id);
        @(negedge clk); cpl_valid = 1'b1; cpl_id = id;
        @(negedge clk); cpl_valid = 1'b0;
    endtask

    // Monitor: compare each descriptor the engine takes against the queue
    always @(negedge clk) begin
        #1;
        if (!rst && desc_valid && desc_ready) begin
            if (exp_q.size() == 0) begin
                check("R4", "unexpected descriptor taken", 32'h1, 32'h0);
            end else begin
                mon_e = exp_q.pop_front();
                check("R2", "desc_id", {27'b0, desc_id}, {27'b0, mon_e.id});
                check("R4", "desc_src_addr", desc_src_addr, mon_e.sa);
                check("R4", "desc_dst_addr", desc_dst_addr, mon_e.da);
                check("R4", "desc_x_len", desc_x_len, mon_e.xl);
                check("R4", "desc_y_len", desc_y_len, mon_e.yl);
                check("R4", "desc_src_stride", desc_src_stride, mon_e.ss);
                check("R4", "desc_dst_stride", desc_dst_stride, mon_e.ds);
                check("R4", "desc_flags", {29'b0, desc_flags}, {29'b0, mon_e.fl});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1", "irq", {31'b0, irq}, 32'h0);
        check("R1", "desc_valid", {31'b0, desc_valid}, 32'h0);
        rd(12'h400, rv); check("R1", "control", rv, 32'h0);
        rd(12'h080, rv); check("R1", "irq mask", rv, 32'h3);
        rd(12'h084, rv); check("R1", "irq pending", rv, 32'h0);
        rd(12'h404, rv); check("R1", "next id", rv, 32'h0);
        rd(12'h408, rv); check("R1", "start", rv, 32'h0);
        rd(12'h428, rv); check("R1", "done", rv, 32'h0);

        // R10 capability probes
        wr(12'h40C, 32'h7);        rd(12'h40C, rv); check("R10", "flags probe", rv, 32'h6);
        wr(12'h418, 32'hFFFF_FFFF); rd(12'h418, rv); check("R10", "x length probe", rv, 32'h0000_FFFF);
        wr(12'h41C, 32'h1);        rd(12'h41C, rv); check("R10", "y length probe", rv, 32'h1);
        wr(12'h410, 32'h1234_5678); rd(12'h410, rv); check("R10", "dest addr probe", rv, 32'h0);
        wr(12'h414, 32'hABCD_0000); rd(12'h414, rv); check("R10", "src addr probe", rv, 32'hABCD_0000);

        // R3 start while disabled is ignored
        wr(12'h408, 32'h1);
        rd(12'h408, rv); check("R3", "start while disabled", rv, 32'h0);
        rd(12'h404, rv); check("R3", "id after rejected start", rv, 32'h0);
        check("R3", "desc_valid while disabled", {31'b0, desc_valid}, 32'h0);

        // Enable and commit the first descriptor
        wr(12'h400, 32'h1);
        commit(32'h8000_0000, 32'h5555_0000, 32'h0000_00FF, 32'h3, 32'h100, 32'h200, 3'b011);
        rd(12'h408, rv); check("R3", "start busy", rv, 32'h1);
        rd(12'h404, rv); check("R2", "next id after commit", rv, 32'h1);
        wr(12'h408, 32'h1);
        rd(12'h404, rv); check("R3", "id after start while busy", rv, 32'h1);
        wr(12'h418, 32'h0000_0042); // R4 later staging must not alter the slot
        check("R4", "desc_x_len after restage", desc_x_len, 32'h0000_00FF);

        // R5 pause
        wr(12'h400, 32'h3);
        check("R5", "desc_valid paused", {31'b0, desc_valid}, 32'h0);
        wr(12'h400, 32'h1);
        check("R5", "desc_valid resumed", {31'b0, desc_valid}, 32'h1);

        // R8 / R9 slot-free interrupt
        wr(12'h080, 32'h0);
        take();
        rd(12'h408, rv); check("R3", "start after take", rv, 32'h0);
        rd(12'h084, rv); check("R8", "pending after take", rv, 32'h1);
        check("R9", "irq unmasked", {31'b0, irq}, 32'h1);
        wr(12'h080, 32'h1);
        check("R9", "irq masked", {31'b0, irq}, 32'h0);
        rd(12'h088, rv); check("R8", "source masked", rv, 32'h0);
        wr(12'h084, 32'h1);
        rd(12'h084, rv); check("R8", "pending cleared", rv, 32'h0);

        // R7 completion and clear-on-read
        finish_id(5'd0);
        check("R9", "irq on finish", {31'b0, irq}, 32'h1);
        rd(12'h428, rv); check("R7", "done first read", rv, 32'h1);
        rd(12'h428, rv); check("R7", "done second read", rv, 32'h0);
        wr(12'h084, 32'h2);
        check("R8", "irq after clear", {31'b0, irq}, 32'h0);

        // R7 read and completion in the same cycle
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 12'h428; cpl_valid = 1'b1; cpl_id = 5'd5;
        @(negedge clk);
        reg_rd = 1'b0; cpl_valid = 1'b0;
        check("R7", "done read racing finish", reg_rdata, 32'h0);
        rd(12'h428, rv); check("R7", "done after race", rv, 32'h20);

        // R8 set wins over clear in the same cycle
        wr(12'h084, 32'h3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h084; reg_wdata = 32'h2; cpl_valid = 1'b1; cpl_id = 5'd6;
        @(negedge clk);
        reg_wr = 1'b0; cpl_valid = 1'b0;
        rd(12'h084, rv); check("R8", "set wins over clear", rv, 32'h2);
        rd(12'h428, rv); check("R7", "done id 6", rv, 32'h40);
        wr(12'h084, 32'h3);

        // R2 wrap through all IDs
        for (int i = 1; i < 32; i++) begin
            commit(32'h1000_0000 + 32'(i) * 32'h100, 32'h0, 32'(i), 32'(i + 1),
                   32'(i * 4), 32'(i * 8), 3'(i));
            take();
        end
        rd(12'h404, rv); check("R2", "next id wrapped", rv, 32'h0);
        rd(12'h42C, rv); check("R2", "active id", rv, 32'd31);

        // R7 ID 31 has no done bit
        finish_id(5'd31);
        rd(12'h428, rv); check("R7", "done for id 31", rv, 32'h0);
        rd(12'h084, rv); check("R8", "finish pending for id 31", rv & 32'h2, 32'h2);
        wr(12'h084, 32'h3);

        // R6 abort
        commit(32'h2222_0000, 32'h0, 32'h10, 32'h0, 32'h0, 32'h0, 3'b010);
        check("R6", "desc_valid before abort", {31'b0, desc_valid}, 32'h1);
        wr(12'h400, 32'h0);
        void'(exp_q.pop_back());
        check("R6", "desc_valid after abort", {31'b0, desc_valid}, 32'h0);
        rd(12'h408, rv); check("R6", "start after abort", rv, 32'h0);
        wr(12'h400, 32'h1);
        check("R6", "slot empty after re-enable", {31'b0, desc_valid}, 32'h0);
        rd(12'h404, rv); check("R2", "next id after abort", rv, {27'b0, model_id});

        repeat (4) @(negedge clk);
        check("R4", "scoreboard drained", exp_q.size(), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule